// File: doc/BRIEF.md
# IPv4 Header Validity Checker

This block inspects an IPv4 header as it streams past, one byte per clock, and decides whether a router may accept it. Alongside the first byte of each packet the link layer presents the length it measured for that packet. When the header has been fully received the block raises a single-cycle verdict with a pass flag and a reason code.

Five conditions are judged: the link-measured length must hold at least a minimum 20-byte header, the version nibble must read 4, the header-length field (in 32-bit words) must be at least 5, the total-length field must be no smaller than the header it describes, and the 16-bit ones-complement sum over every header byte, options included, must come to 0xFFFF. When several conditions fail, one reason is chosen by fixed priority. A start-of-packet marker always restarts the checker, and bytes that arrive after a verdict and before the next start are ignored.

Top module: `ipv4_hdr_check`

## Requirements
- R1: After reset `done` is low and stays low until a packet's bytes are accepted.
- R2: A well-formed header produces `done` high for exactly one cycle, in the cycle after its last header byte (byte index IHL*4-1, byte 0 carrying the start marker) is accepted, with `pass`=1 and `reason`=0.
- R3: If the link length is below 20, the verdict has `reason`=1 and arrives in the cycle after byte index link_len-1 is accepted (after byte 0 when the link length is 0 or 1).
- R4: If the ones-complement sum of all IHL*4 header bytes, taken as big-endian 16-bit words, is not 0xFFFF, the verdict has `reason`=5.
- R5: If the upper nibble of byte 0 is not 4, the verdict has `reason`=2.
- R6: If the lower nibble of byte 0 (IHL) is below 5, the verdict has `reason`=3 and is given after byte index 19.
- R7: If the total-length field (bytes 2 and 3, big-endian) is below IHL*4, the verdict has `reason`=4; a value equal to IHL*4 passes.
- R8: Headers with options (IHL from 6 to 15) are checked over all IHL*4 bytes and the verdict follows byte index IHL*4-1.
- R9: If the link length is at least 20 but below IHL*4, the verdict has `reason`=1 and follows byte index link_len-1.
- R10: With several faults present, the reported code is the first failing one in the order link length (1), version (2), IHL (3), total length (4), checksum (5); `pass` is 1 exactly when `reason` is 0.
- R11: Cycles with `in_valid` low do not advance the header, a start marker restarts checking from byte 0, and bytes without a start marker after a verdict produce no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A header byte is present on `in_data` |
| in_sop | input | 1 | This byte is byte 0 of a new packet |
| in_data | input | 8 | Header byte |
| in_link_len | input | LEN_W | Packet length in bytes measured by the link layer, read with the start byte |
| done | output | 1 | One-cycle verdict strobe |
| pass | output | 1 | Header accepted, valid with `done` |
| reason | output | 3 | 0 pass, 1 link length, 2 version, 3 IHL, 4 total length, 5 checksum |

## Verification
Headers are sent with IHL of 4, 5, 6, 7 and 15, so that the verdict cycle shows whether the end of the header follows the header-length field or the fixed 20-byte floor. Link lengths of 0, 12, 19, 20 and 40 separate the early stop on a short link from a full-header verdict, and tell the absolute minimum from the options-aware bound. Single faults in version, total length and checksum isolate each code, while stacked faults reveal the priority order. Idle gaps, an abandoned partial packet and stray bytes without a start marker show that only accepted bytes of the current packet count.

// File: rtl/ipv4_chk_pkg.sv
package ipv4_chk_pkg;
  localparam int MIN_HDR_BYTES = 20;
  localparam int MIN_IHL       = 5;
  localparam logic [3:0] IP_VERSION = 4'd4;

  typedef enum logic [2:0] {
    RSN_OK   = 3'd0,
    RSN_LINK = 3'd1,
    RSN_VER  = 3'd2,
    RSN_IHL  = 3'd3,
    RSN_TLEN = 3'd4,
    RSN_CSUM = 3'd5
  } reason_e;
endpackage

// File: rtl/ipv4_hdr_fields.sv
// Captures the fixed header fields needed by the verdict logic.
module ipv4_hdr_fields #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output logic [3:0]       version,
  output logic [3:0]       ihl,
  output logic [15:0]      tot_len
);
  always_ff @(posedge clk) begin
    if (rst) begin
      version <= '0;
      ihl     <= '0;
      tot_len <= '0;
    end else if (en) begin
      case (idx)
        IDX_W'(0): begin
          version <= data[7:4];
          ihl     <= data[3:0];
        end
        IDX_W'(2): tot_len[15:8] <= data;
        IDX_W'(3): tot_len[7:0]  <= data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ipv4_csum_acc.sv
// Running ones-complement sum; ok reflects the sum including the current byte.
module ipv4_csum_acc #(
  parameter int SUM_W = 22
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic start,
  input  logic low_half,
  input  logic [7:0] data,
  output logic ok
);
  logic [SUM_W-1:0] sum_q, sum_d, base, addend;
  logic [16:0] fold1;
  logic [16:0] fold2;

  always_comb begin
    base   = start ? '0 : sum_q;
    addend = low_half ? SUM_W'({8'h00, data}) : SUM_W'({data, 8'h00});
    sum_d  = base + addend;
    fold1  = {1'b0, sum_d[15:0]} + 17'(sum_d[SUM_W-1:16]);
    fold2  = {1'b0, fold1[15:0]} + 17'(fold1[16]);
    ok     = (fold2[15:0] == 16'hFFFF);
  end

  always_ff @(posedge clk) begin
    if (rst)     sum_q <= '0;
    else if (en) sum_q <= sum_d;
  end
endmodule

// File: rtl/ipv4_hdr_check.sv
module ipv4_hdr_check
  import ipv4_chk_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int IHL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  input  logic [LEN_W-1:0] in_link_len,
  output logic             done,
  output logic             pass,
  output logic [2:0]       reason
);
  localparam int IDX_W = IHL_W + 2;
  localparam int SUM_W = 16 + IDX_W;

  logic             active_q;
  logic [IDX_W-1:0] idx_q, idx_cur;
  logic [IDX_W:0]   idx_nxt;
  logic [LEN_W-1:0] link_q, link_cur;
  logic             accept, link_end, hdr_end, last, len_short, sum_ok;
  logic [3:0]       f_ver, f_ihl;
  logic [15:0]      f_tlen;
  logic [IDX_W-1:0] hdr_bytes;
  reason_e          rsn;

  assign accept   = in_valid & (in_sop | active_q);
  assign idx_cur  = in_sop ? '0 : idx_q;
  assign link_cur = in_sop ? in_link_len : link_q;
  assign idx_nxt  = {1'b0, idx_cur} + 1'b1;

  ipv4_hdr_fields #(.IDX_W(IDX_W)) fields_i (
    .clk(clk), .rst(rst), .en(accept), .idx(idx_cur), .data(in_data),
    .version(f_ver), .ihl(f_ihl), .tot_len(f_tlen)
  );

  ipv4_csum_acc #(.SUM_W(SUM_W)) csum_i (
    .clk(clk), .rst(rst), .en(accept), .start(in_sop),
    .low_half(idx_cur[0]), .data(in_data), .ok(sum_ok)
  );

  always_comb begin
    hdr_bytes = (f_ihl < 4'(MIN_IHL)) ? IDX_W'(MIN_HDR_BYTES)
                                      : IDX_W'({f_ihl, 2'b00});
    link_end  = (LEN_W'(idx_nxt) >= link_cur);
    hdr_end   = (idx_cur != '0) && (idx_nxt == {1'b0, hdr_bytes});
    last      = accept & (link_end | hdr_end);
    len_short = (link_cur < LEN_W'(MIN_HDR_BYTES)) ||
                (link_cur < LEN_W'(hdr_bytes));
    if (len_short)                         rsn = RSN_LINK;
    else if (f_ver != IP_VERSION)          rsn = RSN_VER;
    else if (f_ihl < 4'(MIN_IHL))          rsn = RSN_IHL;
    else if (f_tlen < 16'({f_ihl, 2'b00})) rsn = RSN_TLEN;
    else if (!sum_ok)                      rsn = RSN_CSUM;
    else                                   rsn = RSN_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      link_q   <= '0;
      done     <= 1'b0;
      pass     <= 1'b0;
      reason   <= '0;
    end else begin
      done <= last;
      if (accept) begin
        idx_q    <= idx_nxt[IDX_W-1:0];
        link_q   <= link_cur;
        active_q <= ~last;
      end
      if (last) begin
        pass   <= (rsn == RSN_OK);
        reason <= rsn;
      end
    end
  end
endmodule

module ipv4_hdr_check_sva #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_sop,
  input logic [7:0]       in_data,
  input logic [LEN_W-1:0] in_link_len,
  input logic             done,
  input logic             pass,
  input logic [2:0]       reason
);
  logic [LEN_W-1:0] link_cap;
  logic [7:0]       first_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      link_cap  <= '0;
      first_cap <= '0;
    end else if (in_valid && in_sop) begin
      link_cap  <= in_link_len;
      first_cap <= in_data;
    end
  end

  assert_pass_code_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass == (reason == 3'd0)));

  assert_reason_range_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (reason <= 3'd5));

  assert_short_link_R3: assert property (@(posedge clk) disable iff (rst)
    (done && link_cap < LEN_W'(20)) |-> (reason == 3'd1));

  assert_version_R5: assert property (@(posedge clk) disable iff (rst)
    (done && link_cap >= LEN_W'(60) && first_cap[7:4] != 4'd4) |-> (reason == 3'd2));

  assert_needs_byte_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(in_valid));
endmodule

bind ipv4_hdr_check ipv4_hdr_check_sva #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
  .in_data(in_data), .in_link_len(in_link_len),
  .done(done), .pass(pass), .reason(reason)
);

// File: tb/ipv4_hdr_check_tb.sv
module ipv4_hdr_check_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sop = 1'b0;
  logic [7:0]  in_data = '0;
  logic [15:0] in_link_len = '0;
  logic        done, pass;
  logic [2:0]  reason;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] hb [0:63];

  always #10 clk = ~clk;

  ipv4_hdr_check dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .in_link_len(in_link_len),
    .done(done), .pass(pass), .reason(reason)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Fill a header, compute a valid checksum over nbytes.
  task automatic build_hdr(input int ver, input int ihl, input int tlen, input int nbytes);
    int s;
    for (int i = 0; i < 64; i++) hb[i] = 8'(i * 7 + 3);
    hb[0]  = {4'(ver), 4'(ihl)};
    hb[2]  = 8'(tlen >> 8);
    hb[3]  = 8'(tlen);
    hb[10] = 8'h00;
    hb[11] = 8'h00;
    s = 0;
    for (int i = 0; i < nbytes; i += 2) s += {hb[i], hb[i+1]};
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    s = ~s & 32'hFFFF;
    hb[10] = 8'(s >> 8);
    hb[11] = 8'(s);
  endtask

  // Drive n_send bytes; expect a verdict after byte index exp_last (-2: none).
  task automatic send_pkt(input string req, input int n_send, input int link,
                          input int exp_last, input int exp_reason,
                          input bit gaps, input bit with_sop);
    int i = 0;
    int prev = -1;
    bit tfail = 0;
    bit gap_done = 0;
    int got_r = -1;
    int got_p = -1;
    int seen_at = -3;
    while (i < n_send || prev != -1) begin
      @(negedge clk);
      if (done) begin
        got_r = reason; got_p = pass; seen_at = prev;
        if (prev != exp_last || prev == -1) tfail = 1;
      end else if (prev == exp_last) tfail = 1;
      if (i < n_send && !(gaps && (i % 3 == 1) && !gap_done)) begin
        in_valid    = 1'b1;
        in_sop      = with_sop && (i == 0);
        in_data     = hb[i];
        in_link_len = 16'(link);
        prev = i; i++; gap_done = 0;
      end else begin
        in_valid = 1'b0; in_sop = 1'b0;
        prev = -1;
        if (i < n_send) gap_done = 1;
      end
    end
    @(negedge clk);
    if (done) tfail = 1;
    check(!tfail, req, "verdict timing (byte index of verdict)", seen_at, exp_last);
    if (exp_last >= 0) begin
      check(got_r == exp_reason, req, "reason", got_r, exp_reason);
      check(got_p == (exp_reason == 0 ? 1 : 0), req, "pass", got_p,
            exp_reason == 0 ? 1 : 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R1", "done after reset", done, 0);

    // R2: plain header, ample link length; and exact 20-byte link
    build_hdr(4, 5, 100, 20);
    send_pkt("R2", 20, 64, 19, 0, 0, 1);
    send_pkt("R2", 20, 20, 19, 0, 0, 1);

    // R8: options
    build_hdr(4, 8, 200, 32);
    send_pkt("R8", 32, 200, 31, 0, 0, 1);
    build_hdr(4, 15, 60, 60);
    send_pkt("R8", 60, 60, 59, 0, 0, 1);

    // R3: short link
    build_hdr(4, 5, 100, 20);
    send_pkt("R3", 20, 19, 18, 1, 0, 1);
    send_pkt("R3", 20, 12, 11, 1, 0, 1);
    send_pkt("R3", 20, 0, 0, 1, 0, 1);

    // R4: bad checksum
    build_hdr(4, 5, 100, 20);
    hb[15] = hb[15] ^ 8'h01;
    send_pkt("R4", 20, 64, 19, 5, 0, 1);

    // R5: version
    build_hdr(6, 5, 100, 20);
    send_pkt("R5", 20, 64, 19, 2, 0, 1);

    // R6: IHL below 5, verdict after byte 19
    build_hdr(4, 4, 100, 20);
    send_pkt("R6", 24, 64, 19, 3, 0, 1);

    // R7: total length too small, and equal boundary
    build_hdr(4, 6, 20, 24);
    send_pkt("R7", 24, 64, 23, 4, 0, 1);
    build_hdr(4, 6, 24, 24);
    send_pkt("R7", 24, 64, 23, 0, 0, 1);

    // R9: link shorter than options header
    build_hdr(4, 15, 100, 60);
    send_pkt("R9", 60, 40, 39, 1, 0, 1);

    // R10: priority with stacked faults
    build_hdr(6, 4, 4, 20);
    hb[17] = hb[17] ^ 8'h40;
    send_pkt("R10", 20, 64, 19, 2, 0, 1);
    send_pkt("R10", 20, 10, 9, 1, 0, 1);
    build_hdr(4, 4, 4, 20);
    hb[17] = hb[17] ^ 8'h40;
    send_pkt("R10", 20, 64, 19, 3, 0, 1);

    // R11: gaps, abandoned partial packet, stray bytes
    build_hdr(4, 7, 300, 28);
    send_pkt("R11", 28, 300, 27, 0, 1, 1);
    build_hdr(5, 9, 1, 36);
    send_pkt("R11", 12, 64, -2, 0, 0, 1);
    build_hdr(4, 5, 100, 20);
    send_pkt("R11", 20, 64, 19, 0, 0, 1);
    send_pkt("R11", 20, 64, -2, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule